// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer that sits beside a local interrupt controller. Software programs three registers through a small write/read port: a control entry that holds an 8-bit vector, a mask bit and a periodic bit; a start count; and a divide setting. The timer counts a base tick input through a power-of-two prescaler. It decrements a current-count register that software can read back at any time.

In one-shot mode the count falls from the start value to zero and stays there. One scaled tick after it reaches zero, the timer raises a single request. In periodic mode the count reloads from the start value on the scaled tick after zero, so each period lasts the start count plus one scaled ticks, and a request goes out at every reload. A request is a one-cycle pulse on `irq`, with the vector on `irq_vec`. A masked timer keeps counting but never raises a request. Prioritising requests and delivering them to a processor are outside this block.

Top module: `lapic_countdown`

## Requirements
- R1: After reset the control entry reads 0x0001_0000, which is masked, one-shot, vector 0. The start count, the current count and the divide setting all read 0.
- R2: The divide setting stores only bits 0, 1 and 3 of the written word. A read returns the written value ANDed with 0xB.
- R3: The divide code is v = {bit3, bit1, bit0} of the divide setting. The prescale ratio is 2^((v+1) mod 8) base ticks per scaled tick, so code 7 divides by 1 and code 6 divides by 128.
- R4: Writing the start count (address 1) loads the current count with the written value and clears the prescaler. The j-th scaled tick then falls on the (j·ratio)-th counted base tick after the write.
- R5: In one-shot mode (control bit 17 = 0), after d scaled ticks the current count reads max(start − d, 0). It then holds at 0.
- R6: In one-shot mode with a non-zero start, exactly one request is raised: on scaled tick start+1, if bit 16 = 0. The request is `irq` high for one cycle, the cycle after that clock edge, with `irq_vec` equal to control bits 7:0.
- R7: In one-shot mode a start count of 0 never raises a request.
- R8: In periodic mode (control bit 17 = 1) the current count reads start − (d mod (start+1)). A request is raised on every scaled tick where d is a non-zero multiple of start+1.
- R9: With the mask bit (bit 16) set, no request is raised, and the current count still follows R5 or R8.
- R10: The control entry (address 0) keeps only bits 7:0, 16 and 17. All other bits read 0.
- R11: A clock cycle with `base_tick` low advances neither the prescaler nor the count.
- R12: The current count (address 2) is read-only, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Base tick enable, counted when high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 start count, 2 current count, 3 divide |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | One-cycle request pulse |
| irq_vec | output | 8 | Vector that goes with the request |

## Verification
A wrong prescaler phase or a wrong divide decode shows on the current-count readback within one prescale period, because the count drops a cycle early or late. A wrong reload value, or an off-by-one in expiry, shows at the end of the first period: the pulse arrives a scaled tick early or late, or the count jumps to a value outside the start-minus-elapsed sequence. A stale expiry flag appears only after the count reaches zero, as a second one-shot pulse or a missing one. The bench therefore compares the count and the pulse every cycle for whole runs, across several periods.

// File: rtl/lapic_countdown.sv
module lapic_countdown #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [7:0]  irq_vec
);
  localparam int PRE_W = 7;

  logic [7:0]       lvt_vec_q;
  logic             lvt_mask_q;
  logic             lvt_per_q;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] cur_q;
  logic [3:0]       div_q;
  logic [PRE_W-1:0] pre_q;
  logic             armed_q;

  logic [2:0]       div_code;
  logic [2:0]       shift;
  logic [PRE_W-1:0] pre_mask;
  logic             scaled;
  logic             wr_lvt, wr_init, wr_div;
  logic             expire;

  assign div_code = {div_q[3], div_q[1:0]};
  assign shift    = div_code + 3'd1;
  assign pre_mask = PRE_W'((8'd1 << shift) - 8'd1);
  assign scaled   = base_tick && ((pre_q & pre_mask) == pre_mask);

  assign wr_lvt  = reg_wr && (reg_addr == 2'd0);
  assign wr_init = reg_wr && (reg_addr == 2'd1);
  assign wr_div  = reg_wr && (reg_addr == 2'd3);

  assign expire = scaled && (cur_q == '0) && (lvt_per_q || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvt_vec_q  <= 8'h00;
      lvt_mask_q <= 1'b1;
      lvt_per_q  <= 1'b0;
      init_q     <= '0;
      cur_q      <= '0;
      div_q      <= 4'h0;
      pre_q      <= '0;
      armed_q    <= 1'b0;
      irq        <= 1'b0;
      irq_vec    <= 8'h00;
    end else begin
      irq <= 1'b0;
      if (wr_lvt) begin
        lvt_vec_q  <= reg_wdata[7:0];
        lvt_mask_q <= reg_wdata[16];
        lvt_per_q  <= reg_wdata[17];
      end
      if (wr_div)
        div_q <= reg_wdata[3:0] & 4'hB;
      if (wr_init) begin
        init_q  <= reg_wdata[CNT_W-1:0];
        cur_q   <= reg_wdata[CNT_W-1:0];
        pre_q   <= '0;
        armed_q <= |reg_wdata[CNT_W-1:0];
      end else begin
        if (base_tick)
          pre_q <= pre_q + 1'b1;
        if (scaled) begin
          if (cur_q != '0)
            cur_q <= cur_q - 1'b1;
          else if (lvt_per_q)
            cur_q <= init_q;
          else
            armed_q <= 1'b0;
        end
        if (expire) begin
          irq     <= !lvt_mask_q;
          irq_vec <= lvt_vec_q;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'({lvt_per_q, lvt_mask_q, 8'h00, lvt_vec_q});
      2'd1:    reg_rdata = 32'(init_q);
      2'd2:    reg_rdata = 32'(cur_q);
      default: reg_rdata = {28'h0, div_q};
    endcase
  end
endmodule

// File: rtl/lapic_countdown_chk.sv
module lapic_countdown_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_addr,
  input logic             irq,
  input logic [7:0]       irq_vec,
  input logic [7:0]       lvt_vec,
  input logic             lvt_mask,
  input logic             lvt_per,
  input logic [CNT_W-1:0] init_cnt,
  input logic [CNT_W-1:0] cur_cnt
);
  logic wr_init;
  assign wr_init = reg_wr && (reg_addr == 2'd1);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (lvt_mask && !lvt_per && init_cnt == '0 && cur_cnt == '0));

  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvt_per && cur_cnt == '0 && !wr_init && !(reg_wr && reg_addr == 2'd0)) |=> cur_cnt == '0);

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_init && cur_cnt != '0) |=> (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - 1'b1));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !lvt_per && !(reg_wr && reg_addr == 2'd0)) |=> !irq);

  p_vec_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_vec == $past(lvt_vec));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt <= init_cnt);

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvt_mask |=> !irq);
endmodule

bind lapic_countdown lapic_countdown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .irq      (irq),
  .irq_vec  (irq_vec),
  .lvt_vec  (lvt_vec_q),
  .lvt_mask (lvt_mask_q),
  .lvt_per  (lvt_per_q),
  .init_cnt (init_q),
  .cur_cnt  (cur_q)
);

// File: tb/tb_lapic_countdown.sv
`timescale 1ns/1ps
module tb_lapic_countdown;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [7:0]  irq_vec;

  int total = 0;
  int fails = 0;
  bit done = 0;

  longint m_init, m_T, m_d;
  int     m_shift;
  bit     m_per, m_mask;
  logic [7:0] m_vec;

  always #5 clk = ~clk;

  lapic_countdown dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .irq_vec(irq_vec)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_count();
    if (m_per) return m_init - (m_d % (m_init + 1));
    return (m_d >= m_init) ? 0 : m_init - m_d;
  endfunction

  function automatic logic [31:0] div_word(input int code);
    return {28'h0, code[2], 1'b0, code[1:0]};
  endfunction

  task automatic write_reg(input logic [1:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v; base_tick = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, req, reg_rdata, exp);
    reg_addr = 2'd2;
  endtask

  task automatic step(input bit tk);
    bit fire;
    fire = 0;
    base_tick = tk;
    @(posedge clk);
    if (tk) begin
      m_T++;
      if (m_T % (64'd1 << m_shift) == 0) begin
        m_d = m_T >> m_shift;
        if (m_per) fire = (m_d % (m_init + 1)) == 0;
        else       fire = (m_init != 0) && (m_d == m_init + 1);
      end
    end
    @(negedge clk);
    #1;
    if (m_mask)
      check(irq === 1'b0, "R9 irq", irq, 0);
    else if (m_per)
      check(irq === fire, "R8 irq", irq, fire);
    else
      check(irq === fire, "R6/R7 irq", irq, fire);
    if (fire && !m_mask)
      check(irq_vec === m_vec, "R6 vector", irq_vec, m_vec);
    check(reg_rdata == 32'(exp_count()), m_per ? "R3/R8 count" : "R3/R5 count",
          reg_rdata, exp_count());
  endtask

  task automatic run(input int code, input longint init, input bit per, input bit msk,
                     input logic [7:0] vec, input int cycles, input int tick_pct);
    write_reg(2'd3, div_word(code));
    write_reg(2'd0, {14'h0, per, msk, 8'h00, vec});
    write_reg(2'd1, 32'(init));
    m_init = init; m_per = per; m_mask = msk; m_vec = vec;
    m_shift = (code + 1) % 8; m_T = 0; m_d = 0;
    read_chk(2'd2, 32'(init), "R4 reload");
    for (int i = 0; i < cycles; i++)
      step(($urandom % 100) < tick_pct);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk(2'd0, 32'h0001_0000, "R1 control");
    read_chk(2'd1, 32'h0, "R1 start");
    read_chk(2'd2, 32'h0, "R1 current");
    read_chk(2'd3, 32'h0, "R1 divide");

    write_reg(2'd0, 32'hFFFF_FFFF);
    read_chk(2'd0, 32'h0003_00FF, "R10 control bits");
    write_reg(2'd3, 32'hFFFF_FFFF);
    read_chk(2'd3, 32'h0000_000B, "R2 divide bits");
    write_reg(2'd3, 32'h0000_0004);
    read_chk(2'd3, 32'h0, "R2 divide bit2");
    write_reg(2'd0, 32'h0001_0000);

    write_reg(2'd1, 32'd9);
    write_reg(2'd2, 32'd3);
    read_chk(2'd2, 32'd9, "R12 current write");
    read_chk(2'd1, 32'd9, "R12 start kept");

    write_reg(2'd3, div_word(7));
    write_reg(2'd1, 32'd6);
    for (int i = 0; i < 10; i++) begin
      base_tick = 1'b0;
      @(negedge clk);
    end
    read_chk(2'd2, 32'd6, "R11 no tick");

    run(7, 5, 0, 0, 8'h31, 20, 100);
    run(0, 3, 0, 0, 8'hA5, 20, 100);
    run(3, 2, 0, 0, 8'h07, 60, 100);
    run(7, 0, 0, 0, 8'h44, 20, 100);
    run(7, 4, 1, 0, 8'h52, 40, 100);
    run(1, 2, 1, 0, 8'hC3, 60, 100);
    run(6, 1, 1, 0, 8'h19, 600, 100);
    run(2, 3, 1, 0, 8'h80, 200, 100);
    run(7, 0, 1, 0, 8'h11, 10, 100);
    run(7, 3, 1, 1, 8'h22, 30, 100);
    run(0, 2, 0, 1, 8'h23, 20, 100);
    for (int k = 0; k < 12; k++) begin
      int code;
      code = $urandom % 6;
      if (code == 5) code = 7;
      run(code, $urandom % 10, $urandom % 2, ($urandom % 4) == 0,
          8'($urandom), 300, 60);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule